// File: doc/BRIEF.md
# Single-Wire Return-to-One Register Slave

This block is the device side of a one-wire, open-drain serial link that lets a host read and write a small register file. The host opens every exchange with a long low break followed by a recovery high. It then sends an 8-bit command, least-significant bit first. Bit 7 of the command selects the direction: 1 for a write and 0 for a read. Bits 6:0 hold the register address. On a write the host sends one more byte, and the slave stores it. On a read the slave drives the addressed byte back, again LSB first, through an output enable that can only pull the wire low.

Every bit travels in a return-to-one cell. A falling edge opens the cell, and the level a fixed time after that edge carries the data. All timing is counted in cycles of the system clock. The basic step is one "unit" of `UNIT_CYC` cycles, which is nominally 250 µs. The slave holds five read/write registers, three read-only values supplied by the surrounding logic, and a write-only reset location. Writing the key value to the reset location restores the register defaults.

Top module: `swr_slave`

## Requirements
- R1: After rst_n is released, dq_oe_o is 0 and soft_rst_o is 0. The register outputs hold their defaults: cnt_hi_o, id_o and cap_o are 00h, filt_o is 96h and thr_o is 70h.
- R2: Until a break has been seen, the slave ignores traffic and never drives the wire. A break is the filtered line held low for at least BRK_UNITS units (12), followed by REC_UNITS units (4) of continuous high.
- R3: Each received bit is the filtered line level SAMPLE_UNITS units (4) after the filtered falling edge that opens the cell. Bits arrive LSB first. In the command byte, bit 7 = 1 means write and bit 7 = 0 means read, and bits 6:0 are the address.
- R4: A write command to address 03h, 04h, 05h, 0Ah or 0Ch stores the following data byte. The stored byte appears on cnt_hi_o, id_o, cap_o, filt_o or thr_o respectively.
- R5: For a read, the slave starts its first cell TURN_UNITS units (10) after sampling the last command bit. Each cell lasts CELL_UNITS units (16). In each cell the wire is pulled low for START_UNITS units (1); for a 0 bit it stays low until HOLD_UNITS units (6). Bits are sent LSB first.
- R6: Reading 01h returns flags_i, 02h returns temp_i and 17h returns cnt_lo_i. Reading any of the five writable addresses returns its stored value.
- R7: Reading an unmapped address, including the write-only reset address 39h, returns 00h.
- R8: A write to a read-only or unmapped address changes no register output.
- R9: Writing 80h to address 39h raises soft_rst_o for exactly one cycle, restores all writable registers to their defaults, and returns the slave to waiting for a break. Writing any other value to 39h has no effect.
- R10: A break detected during a command byte or a write data byte abandons the transfer without writing anything. The slave then accepts a new command after the recovery time.
- R11: A low pulse on dq_i shorter than FILT_LEN clock cycles (3) is neither a bit nor an edge.
- R12: dq_oe_o is asserted only while the slave is transmitting a read response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dq_i | input | 1 | Sensed level of the shared wire |
| dq_oe_o | output | 1 | Pull-low enable for the shared wire |
| flags_i | input | 8 | Status flags byte, read at 01h |
| temp_i | input | 8 | Temperature/gauge byte, read at 02h |
| cnt_lo_i | input | 8 | Count low byte, read at 17h |
| cnt_hi_o | output | 8 | Count high byte register (03h) |
| id_o | output | 8 | Identification register (04h) |
| cap_o | output | 8 | Learned capacity register (05h) |
| filt_o | output | 8 | Filter setting register (0Ah) |
| thr_o | output | 8 | Threshold register (0Ch) |
| soft_rst_o | output | 1 | One-cycle pulse on a keyed reset write |

## Verification
A register output changes at the sample point of the eighth data bit. That point is SAMPLE_UNITS units, plus the synchroniser and filter delay, after the falling edge of that bit's cell. The bench therefore reads the register outputs only after the whole 12-unit host cell has elapsed. A read response begins TURN_UNITS units after the last command sample. The monitor locks onto each rise of dq_oe_o and samples the wire four units later, inside the window where the data level is guaranteed. The read task waits 150 units, which is longer than the full 8-cell response, before starting the next stimulus. The soft reset pulse is counted as it happens. Runs in which no response may appear are checked by comparing the received-byte and enable-rise counts before and after the run.

// File: rtl/swr_pkg.sv
package swr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BRK,
        ST_CMD,
        ST_WDAT,
        ST_TURN,
        ST_TX
    } swr_state_e;

    localparam int NUM_RW = 5;

    // writable register addresses; index 0..4 = count high, id, capacity, filter, threshold
    localparam logic [NUM_RW-1:0][6:0] RW_ADDR = {7'h0C, 7'h0A, 7'h05, 7'h04, 7'h03};
    localparam logic [NUM_RW-1:0][7:0] RW_INIT = {8'h70, 8'h96, 8'h00, 8'h00, 8'h00};

    localparam logic [6:0] A_FLAGS  = 7'h01;
    localparam logic [6:0] A_TEMP   = 7'h02;
    localparam logic [6:0] A_CNTLO  = 7'h17;
    localparam logic [6:0] A_RESET  = 7'h39;
    localparam logic [7:0] RESET_KEY = 8'h80;

endpackage

// File: rtl/swr_rx_filter.sv
module swr_rx_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic line_o,
    output logic fall_o
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] CNT_END = CW'(FILT_LEN - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          line;
        logic          prev;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t q, d;

    always_comb begin
        d      = q;
        d.s1   = pin_i;
        d.s2   = q.s1;
        d.prev = q.line;
        if (q.s2 != q.line) begin
            if (q.cnt == CNT_END) begin
                d.line = q.s2;
                d.cnt  = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{s1: 1'b1, s2: 1'b1, line: 1'b1, prev: 1'b1, cnt: '0};
        end else begin
            q <= d;
        end
    end

    assign line_o = q.line;
    assign fall_o = q.prev & ~q.line;

endmodule

// File: rtl/swr_regs.sv
module swr_regs
    import swr_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [6:0]               addr,
    input  logic [7:0]               wdata,
    input  logic [7:0]               flags_i,
    input  logic [7:0]               temp_i,
    input  logic [7:0]               cnt_lo_i,
    output logic [7:0]               rdata_o,
    output logic [NUM_RW-1:0][7:0]   rw_o,
    output logic                     soft_rst_o
);
    logic       kill;
    logic       soft_q;
    logic [7:0] rw_q [NUM_RW];
    logic [7:0] rw_d [NUM_RW];

    assign kill = wr_en && (addr == A_RESET) && (wdata == RESET_KEY);

    for (genvar i = 0; i < NUM_RW; i++) begin : g_rw
        always_comb begin
            rw_d[i] = rw_q[i];
            if (kill) begin
                rw_d[i] = RW_INIT[i];
            end else if (wr_en && (addr == RW_ADDR[i])) begin
                rw_d[i] = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rw_q[i] <= RW_INIT[i];
            end else begin
                rw_q[i] <= rw_d[i];
            end
        end

        assign rw_o[i] = rw_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soft_q <= 1'b0;
        end else begin
            soft_q <= kill;
        end
    end

    always_comb begin
        rdata_o = 8'h00;
        case (addr)
            A_FLAGS: rdata_o = flags_i;
            A_TEMP:  rdata_o = temp_i;
            A_CNTLO: rdata_o = cnt_lo_i;
            default: rdata_o = 8'h00;
        endcase
        for (int k = 0; k < NUM_RW; k++) begin
            if (addr == RW_ADDR[k]) begin
                rdata_o = rw_q[k];
            end
        end
    end

    assign soft_rst_o = soft_q;

endmodule

// File: rtl/swr_slave.sv
module swr_slave
    import swr_pkg::*;
#(
    parameter int UNIT_CYC     = 62500,
    parameter int FILT_LEN     = 3,
    parameter int BRK_UNITS    = 12,
    parameter int REC_UNITS    = 4,
    parameter int SAMPLE_UNITS = 4,
    parameter int TURN_UNITS   = 10,
    parameter int START_UNITS  = 1,
    parameter int HOLD_UNITS   = 6,
    parameter int CELL_UNITS   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dq_i,
    output logic       dq_oe_o,
    input  logic [7:0] flags_i,
    input  logic [7:0] temp_i,
    input  logic [7:0] cnt_lo_i,
    output logic [7:0] cnt_hi_o,
    output logic [7:0] id_o,
    output logic [7:0] cap_o,
    output logic [7:0] filt_o,
    output logic [7:0] thr_o,
    output logic       soft_rst_o
);
    localparam int BRK_CYC    = BRK_UNITS * UNIT_CYC;
    localparam int REC_CYC    = REC_UNITS * UNIT_CYC;
    localparam int SAMPLE_CYC = SAMPLE_UNITS * UNIT_CYC;
    localparam int TURN_CYC   = TURN_UNITS * UNIT_CYC;
    localparam int START_CYC  = START_UNITS * UNIT_CYC;
    localparam int HOLD_CYC   = HOLD_UNITS * UNIT_CYC;
    localparam int CELL_CYC   = CELL_UNITS * UNIT_CYC;
    localparam int M1   = (BRK_CYC > CELL_CYC) ? BRK_CYC : CELL_CYC;
    localparam int M2   = (TURN_CYC > REC_CYC) ? TURN_CYC : REC_CYC;
    localparam int MAXC = (M1 > M2) ? M1 : M2;
    localparam int TW   = $clog2(MAXC + 2);

    localparam logic [TW-1:0] BRK_END    = TW'(BRK_CYC - 1);
    localparam logic [TW-1:0] BRK_SAT    = TW'(BRK_CYC);
    localparam logic [TW-1:0] REC_END    = TW'(REC_CYC - 1);
    localparam logic [TW-1:0] SAMPLE_END = TW'(SAMPLE_CYC - 1);
    localparam logic [TW-1:0] TURN_END   = TW'(TURN_CYC - 1);
    localparam logic [TW-1:0] CELL_END   = TW'(CELL_CYC - 1);
    localparam logic [TW-1:0] START_LIM  = TW'(START_CYC);
    localparam logic [TW-1:0] HOLD_LIM   = TW'(HOLD_CYC);

    typedef struct packed {
        swr_state_e    st;
        logic [TW-1:0] tmr;
        logic [TW-1:0] lowc;
        logic          armed;
        logic [2:0]    bitn;
        logic [7:0]    sh;
        logic [6:0]    addr;
        logic          oe;
    } slv_t;

    slv_t q, d;

    logic                   line;
    logic                   fall;
    logic                   brk_hit;
    logic                   wr_en;
    logic [7:0]             wr_data;
    logic [7:0]             rdata;
    logic [7:0]             rx_byte;
    logic [NUM_RW-1:0][7:0] rw;
    logic                   tx_busy;

    swr_rx_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (dq_i),
        .line_o (line),
        .fall_o (fall)
    );

    swr_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (q.addr),
        .wdata      (wr_data),
        .flags_i    (flags_i),
        .temp_i     (temp_i),
        .cnt_lo_i   (cnt_lo_i),
        .rdata_o    (rdata),
        .rw_o       (rw),
        .soft_rst_o (soft_rst_o)
    );

    assign rx_byte = {line, q.sh[7:1]};
    assign brk_hit = !line && (q.lowc == BRK_END);

    always_comb begin
        d       = q;
        d.oe    = 1'b0;
        wr_en   = 1'b0;
        wr_data = rx_byte;

        if (!line) begin
            if (q.lowc != BRK_SAT) d.lowc = q.lowc + 1'b1;
        end else begin
            d.lowc = '0;
        end

        case (q.st)
            ST_IDLE: ;
            ST_BRK: begin
                if (line) begin
                    if (q.tmr == REC_END) begin
                        d.st    = ST_CMD;
                        d.tmr   = '0;
                        d.bitn  = '0;
                        d.armed = 1'b0;
                    end else begin
                        d.tmr = q.tmr + 1'b1;
                    end
                end else begin
                    d.tmr = '0;
                end
            end
            ST_CMD, ST_WDAT: begin
                if (!q.armed) begin
                    if (fall) begin
                        d.armed = 1'b1;
                        d.tmr   = '0;
                    end
                end else if (q.tmr == SAMPLE_END) begin
                    d.sh    = rx_byte;
                    d.armed = 1'b0;
                    d.bitn  = q.bitn + 1'b1;
                    if (q.bitn == 3'd7) begin
                        d.bitn = '0;
                        if (q.st == ST_CMD) begin
                            d.addr = rx_byte[6:0];
                            if (rx_byte[7]) begin
                                d.st = ST_WDAT;
                            end else begin
                                d.st  = ST_TURN;
                                d.tmr = '0;
                            end
                        end else begin
                            wr_en = 1'b1;
                            if ((q.addr == A_RESET) && (rx_byte == RESET_KEY)) begin
                                d.st = ST_IDLE;
                            end else begin
                                d.st = ST_CMD;
                            end
                        end
                    end
                end else begin
                    d.tmr = q.tmr + 1'b1;
                end
            end
            ST_TURN: begin
                if (q.tmr == TURN_END) begin
                    d.st   = ST_TX;
                    d.tmr  = '0;
                    d.bitn = '0;
                    d.sh   = rdata;
                end else begin
                    d.tmr = q.tmr + 1'b1;
                end
            end
            ST_TX: begin
                d.oe = (q.tmr < START_LIM) || ((q.tmr < HOLD_LIM) && !q.sh[0]);
                if (q.tmr == CELL_END) begin
                    d.tmr  = '0;
                    d.sh   = {1'b0, q.sh[7:1]};
                    d.bitn = q.bitn + 1'b1;
                    if (q.bitn == 3'd7) begin
                        d.st    = ST_CMD;
                        d.bitn  = '0;
                        d.armed = 1'b0;
                    end
                end else begin
                    d.tmr = q.tmr + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (brk_hit) begin
            d.st    = ST_BRK;
            d.tmr   = '0;
            d.bitn  = '0;
            d.armed = 1'b0;
            d.oe    = 1'b0;
            wr_en   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, tmr: '0, lowc: '0, armed: 1'b0, bitn: '0,
                   sh: '0, addr: '0, oe: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign tx_busy  = (q.st == ST_TX);
    assign dq_oe_o  = q.oe;
    assign cnt_hi_o = rw[0];
    assign id_o     = rw[1];
    assign cap_o    = rw[2];
    assign filt_o   = rw[3];
    assign thr_o    = rw[4];

endmodule

// File: rtl/swr_slave_chk.sv
module swr_slave_chk
    import swr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       dq_oe,
    input logic       soft_rst,
    input logic [7:0] thr,
    input logic [7:0] filt,
    input logic       tx_busy,
    input logic       wr_en
);
    // R12: wire is pulled only during a read response (one cycle of registered lag allowed)
    p_oe_only_tx_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && !$past(tx_busy)) |-> !dq_oe);

    // R9: keyed reset gives a single-cycle pulse
    p_soft_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);

    // R9: defaults are in place while the pulse is up
    p_soft_defaults_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> (thr == RW_INIT[4]) && (filt == RW_INIT[3]));

    // R4: a register write is a single strobe
    p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R4/R12: no write while the slave drives the wire
    p_wr_not_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !dq_oe);

endmodule

bind swr_slave swr_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dq_oe    (dq_oe_o),
    .soft_rst (soft_rst_o),
    .thr      (thr_o),
    .filt     (filt_o),
    .tx_busy  (tx_busy),
    .wr_en    (wr_en)
);

// File: tb/swr_slave_test.sv
module swr_slave_test;
    localparam int U = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_drv = 1'b1;
    logic       dq_oe;
    wire        line = host_drv & ~dq_oe;
    logic [7:0] flags = 8'h5A, temp = 8'hC7, cntlo = 8'hE1;
    logic [7:0] cnt_hi, id, cap, filt, thr;
    logic       soft_rst;

    int checks = 0, fails = 0;
    int rx_bytes = 0, oe_rises = 0, soft_cnt = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    swr_slave #(.UNIT_CYC(U)) uut (
        .clk(clk), .rst_n(rst_n), .dq_i(line), .dq_oe_o(dq_oe),
        .flags_i(flags), .temp_i(temp), .cnt_lo_i(cntlo),
        .cnt_hi_o(cnt_hi), .id_o(id), .cap_o(cap), .filt_o(filt), .thr_o(thr),
        .soft_rst_o(soft_rst)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_u(input int n);
        repeat (n * U) @(negedge clk);
    endtask

    task automatic send_break();
        host_drv = 1'b0; wait_u(14);
        host_drv = 1'b1; wait_u(5);
    endtask

    task automatic send_bit(input logic b);
        host_drv = 1'b0; wait_u(1);
        if (b) host_drv = 1'b1;
        wait_u(7);
        host_drv = 1'b1; wait_u(4);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic write_reg(input logic [6:0] a, input logic [7:0] v);
        send_byte({1'b1, a});
        send_byte(v);
    endtask

    task automatic read_reg(input logic [6:0] a, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        send_byte({1'b0, a});
        wait_u(150);
    endtask

    // monitor: one rise of the enable per transmitted bit, sample inside the data window
    initial begin
        logic [7:0] got;
        int n;
        n = 0;
        got = 8'h00;
        forever begin
            @(posedge dq_oe);
            oe_rises++;
            wait_u(4);
            got = {line, got[7:1]};
            n++;
            if (n == 8) begin
                n = 0;
                rx_bytes++;
                if (exp_q.size() == 0) begin
                    chk("R12 unexpected response", {24'h0, got}, 32'hFFFF_FFFF);
                end else begin
                    chk(tag_q.pop_front(), {24'h0, got}, {24'h0, exp_q.pop_front()});
                end
            end
        end
    end

    always @(posedge clk) if (soft_rst) soft_cnt++;

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 oe", {31'h0, dq_oe}, 0);
        chk("R1 soft", {31'h0, soft_rst}, 0);
        chk("R1 cnt_hi", {24'h0, cnt_hi}, 32'h00);
        chk("R1 id", {24'h0, id}, 32'h00);
        chk("R1 cap", {24'h0, cap}, 32'h00);
        chk("R1 filt", {24'h0, filt}, 32'h96);
        chk("R1 thr", {24'h0, thr}, 32'h70);

        // R2: no break yet, command must be ignored
        b0 = oe_rises;
        send_byte(8'h0C);
        wait_u(150);
        chk("R2 no response before break", oe_rises, b0);

        send_break();
        read_reg(7'h0C, 8'h70, "R5 R6 read threshold default");
        read_reg(7'h0A, 8'h96, "R5 R6 read filter default");

        // R4 writes
        write_reg(7'h04, 8'hA5); chk("R4 id", {24'h0, id}, 32'hA5);
        write_reg(7'h03, 8'h3C); chk("R4 cnt_hi", {24'h0, cnt_hi}, 32'h3C);
        write_reg(7'h05, 8'hC3); chk("R4 cap", {24'h0, cap}, 32'hC3);
        write_reg(7'h0A, 8'h64); chk("R4 filt", {24'h0, filt}, 32'h64);
        write_reg(7'h0C, 8'h81); chk("R4 thr", {24'h0, thr}, 32'h81);

        // R3 R6 read back and read-only inputs
        read_reg(7'h04, 8'hA5, "R3 R6 read id");
        read_reg(7'h0C, 8'h81, "R3 R6 read threshold");
        read_reg(7'h01, 8'h5A, "R6 read flags");
        read_reg(7'h02, 8'hC7, "R6 read temp");
        read_reg(7'h17, 8'hE1, "R6 read count low");

        // R7 unmapped reads
        read_reg(7'h20, 8'h00, "R7 unmapped 20h");
        read_reg(7'h39, 8'h00, "R7 reset address");
        read_reg(7'h7F, 8'h00, "R7 unmapped 7Fh");

        // R8 ignored writes
        write_reg(7'h01, 8'hFF);
        write_reg(7'h17, 8'hFF);
        write_reg(7'h20, 8'hFF);
        chk("R8 cnt_hi kept", {24'h0, cnt_hi}, 32'h3C);
        chk("R8 id kept", {24'h0, id}, 32'hA5);
        chk("R8 cap kept", {24'h0, cap}, 32'hC3);
        chk("R8 filt kept", {24'h0, filt}, 32'h64);
        chk("R8 thr kept", {24'h0, thr}, 32'h81);
        read_reg(7'h20, 8'h00, "R8 unmapped still zero");

        // R9 wrong key
        write_reg(7'h39, 8'h55);
        chk("R9 wrong key no pulse", soft_cnt, 0);
        chk("R9 wrong key id kept", {24'h0, id}, 32'hA5);

        // R11 glitch shorter than filter length
        host_drv = 1'b0;
        repeat (2) @(negedge clk);
        host_drv = 1'b1;
        wait_u(2);
        read_reg(7'h05, 8'hC3, "R11 glitch ignored");

        // R10 break inside write data
        send_byte(8'h84);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        send_break();
        chk("R10 data abort id kept", {24'h0, id}, 32'hA5);
        read_reg(7'h04, 8'hA5, "R10 ready after data abort");
        // R10 break inside command
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        send_break();
        read_reg(7'h0C, 8'h81, "R10 ready after command abort");

        // R9 keyed reset
        write_reg(7'h39, 8'h80);
        chk("R9 single pulse", soft_cnt, 1);
        chk("R9 thr default", {24'h0, thr}, 32'h70);
        chk("R9 filt default", {24'h0, filt}, 32'h96);
        chk("R9 id default", {24'h0, id}, 32'h00);
        chk("R9 cnt_hi default", {24'h0, cnt_hi}, 32'h00);
        b0 = oe_rises;
        send_byte(8'h0C);
        wait_u(150);
        chk("R9 waits for break after reset", oe_rises, b0);
        send_break();
        read_reg(7'h0C, 8'h70, "R9 threshold default read");

        chk("R5 all expected responses seen", exp_q.size(), 0);
        chk("R12 enable rises equal 8 per response", oe_rises, rx_bytes * 8);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule